// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block collects a parameterized set of external interrupt lines, numbered 1 to `NUM_SRC`, and presents one interrupt request to a small processor core. Each line first passes a gateway. The gateway can sense a level or an edge, and it can invert the line. An edge gateway holds a sticky pending bit until software clears it. ID 0 is reserved and means that no source is claimed.

Each source has a 4-bit priority and an enable. A combinational arbiter picks the most urgent pending, enabled source. Equal priorities go to the lowest ID. One global bit reverses the meaning of priority numbers. The core interrupt is raised when the winner beats both a threshold register and a current-priority register in the active order. Software writes a capture register to freeze the winner. It then reads a handler address, which packs a vector-table base with the claimed ID, and it reads the claimed priority from a separate register.

Configuration uses a memory-mapped register bus. Registers that sit next to the core use a small select-indexed port in the style of CSRs.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every priority, enable, gateway mode, the order bit, the threshold, the current priority, the vector base and the claim registers read 0. `irq_o` is low.
- R2: Bus region `addr[14:12]` 0 holds the priorities and region 1 holds the enables. The word for source k sits at offset 4*k, so `addr[11:2]` is k. Priority reads back bits 3:0 and the enable reads back bit 0. Index 0 and indices above `NUM_SRC` read 0, and writes to them change nothing.
- R3: Region 2 holds the gateway mode of source k. Bit 0 selects polarity (1 = active low) and bit 1 selects the trigger (1 = edge). In level mode the pending bit equals the input XOR the polarity, in the same cycle.
- R4: In edge mode, a change of the polarity-corrected input from inactive to active sets a sticky pending bit, visible on the next cycle. The bit holds until any value is written to region 3 at index k. If a new edge and a clear arrive in the same cycle, the edge wins.
- R5: Region 4 word w reads the pending bits, with bit b giving source 32*w+b. Bit 0 of word 0 always reads 0.
- R6: Region 5 index 0, bit 0 selects the order. With the bit at 0 a larger priority is more urgent. `irq_o` rises one cycle after the winner's priority is strictly greater than both the threshold and the current priority, and falls one cycle after that stops being true.
- R7: With the order bit at 1, a smaller priority is more urgent. The winner must then be strictly less than both the threshold and the current priority.
- R8: A disabled source never wins. Neither does a source with priority 0 in standard order or 15 in reversed order.
- R9: Among equally urgent candidates, the lowest ID wins.
- R10: A CSR write to select 2 latches the winner's ID and its priority. With no winner, both latch as 0. The priority reads back at select 3.
- R11: CSR select 5 reads the handler address. Bits 31:10 carry the vector base, bits 9:2 the claimed ID and bits 1:0 read 0.
- R12: CSR select 0 stores the vector base in bits 31:10, and its other bits read 0. Select 1 stores the threshold and select 4 stores the current priority, each in bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | External interrupt lines, bit k is source k |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, combinational from the address |
| csr_we | input | 1 | Core register write strobe |
| csr_sel | input | 3 | Core register select |
| csr_wdata | input | 32 | Core register write data |
| csr_rdata | output | 32 | Core register read data, combinational from the select |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
In level mode the pending bits follow the input lines with no delay. An edge takes one clock to become visible. A register write shows on the read ports in the cycle after its strobe. `irq_o` lags the state it decides on by one register, and a capture shows on the claim registers one cycle after the write. The bench keeps a behavioural model that updates on the same clock edge as the design and compares `irq_o` against it at every falling edge. The directed read checks are made only after a settling wait of several cycles, so each result is sampled after the cycle in which it is due.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int PRIO_W = 4;

  typedef enum logic [2:0] {
    RG_PRIO  = 3'd0,
    RG_EN    = 3'd1,
    RG_GWCTL = 3'd2,
    RG_GWCLR = 3'd3,
    RG_PEND  = 3'd4,
    RG_CFG   = 3'd5
  } region_e;

  typedef enum logic [2:0] {
    CS_VBASE = 3'd0,
    CS_THR   = 3'd1,
    CS_CAPT  = 3'd2,
    CS_CPRIO = 3'd3,
    CS_CUR   = 3'd4,
    CS_HAP   = 3'd5
  } csr_e;

  // Map a raw priority onto an urgency where a larger value always wins.
  function automatic logic [PRIO_W-1:0] urgency(logic [PRIO_W-1:0] p, logic rev);
    return rev ? ~p : p;
  endfunction
endpackage

// File: rtl/eirq_gateway.sv
module eirq_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic pend_o
);
  logic act, rise;
  logic prev_q, prev_d;
  logic sticky_q, sticky_d;

  always_comb begin
    act      = src_i ^ pol_i;
    rise     = edge_i && act && !prev_q;
    prev_d   = act;
    sticky_d = sticky_q;
    if (clr_i) sticky_d = 1'b0;
    if (rise)  sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign pend_o = edge_i ? sticky_q : act;

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pend_o && !clr_i) |=> (pend_o || !edge_i));
endmodule

// File: rtl/eirq_arbiter.sv
module eirq_arbiter
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC:1]          cand_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  logic                      rev_i,
  output logic [ID_W-1:0]           best_id_o,
  output logic [PRIO_W-1:0]         best_urg_o,
  output logic [PRIO_W-1:0]         best_prio_o
);
  logic [PRIO_W-1:0] p, u;

  always_comb begin
    best_id_o   = '0;
    best_urg_o  = '0;
    best_prio_o = '0;
    p = '0;
    u = '0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      p = prio_i[(k-1)*PRIO_W +: PRIO_W];
      u = urgency(p, rev_i);
      // Strict compare in ascending order keeps the lowest ID on ties.
      if (cand_i[k] && (u > best_urg_o)) begin
        best_id_o   = ID_W'(k);
        best_urg_o  = u;
        best_prio_o = p;
      end
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int ADDR_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC:1]  irq_src,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              csr_we,
  input  logic [2:0]        csr_sel,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq_o
);
  localparam int ID_W       = $clog2(NUM_SRC + 1);
  localparam int PEND_WORDS = (NUM_SRC + 32) / 32;
  localparam int IDX_W      = ADDR_W - 5;
  localparam int VB_W       = 22;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rs_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  region_e          region;
  logic [IDX_W-1:0] idx;
  assign region = region_e'(bus_addr[ADDR_W-1 -: 3]);
  assign idx    = bus_addr[ADDR_W-4:2];

  logic [PRIO_W-1:0] prio_q [1:NUM_SRC];
  logic [PRIO_W-1:0] prio_d [1:NUM_SRC];
  logic [NUM_SRC:1]  en_q, en_d, pol_q, pol_d, edge_q, edge_d, clr_hit, pend, cand;
  logic              rev_q, rev_d, irq_q, irq_d, capt;
  logic [PRIO_W-1:0] thr_q, thr_d, cur_q, cur_d, cprio_q, cprio_d;
  logic [VB_W-1:0]   vbase_q, vbase_d;
  logic [ID_W-1:0]   cid_q, cid_d, best_id;
  logic [PRIO_W-1:0] best_urg, best_prio;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;
  logic [PEND_WORDS*32-1:0]  pend_map;
  logic [7:0]        hap_id;
  logic              unused_bits;

  assign unused_bits = ^{bus_addr[1:0], bus_wdata[9:4], csr_wdata[9:4]};

  for (genvar k = 1; k <= NUM_SRC; k++) begin : g_src
    assign prio_flat[(k-1)*PRIO_W +: PRIO_W] = prio_q[k];
    assign clr_hit[k] = bus_we && (region == RG_GWCLR) && (int'(idx) == k);
    eirq_gateway u_gw (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .src_i  (irq_src[k]),
      .pol_i  (pol_q[k]),
      .edge_i (edge_q[k]),
      .clr_i  (clr_hit[k]),
      .pend_o (pend[k])
    );
  end

  assign cand = pend & en_q;

  eirq_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .cand_i      (cand),
    .prio_i      (prio_flat),
    .rev_i       (rev_q),
    .best_id_o   (best_id),
    .best_urg_o  (best_urg),
    .best_prio_o (best_prio)
  );

  // Next-state logic
  always_comb begin
    prio_d  = prio_q;
    en_d    = en_q;
    pol_d   = pol_q;
    edge_d  = edge_q;
    rev_d   = rev_q;
    thr_d   = thr_q;
    cur_d   = cur_q;
    vbase_d = vbase_q;
    cid_d   = cid_q;
    cprio_d = cprio_q;
    capt    = csr_we && (csr_sel == CS_CAPT);
    for (int k = 1; k <= NUM_SRC; k++) begin
      if (bus_we && (int'(idx) == k)) begin
        if (region == RG_PRIO) prio_d[k] = bus_wdata[PRIO_W-1:0];
        if (region == RG_EN)   en_d[k]   = bus_wdata[0];
        if (region == RG_GWCTL) begin
          pol_d[k]  = bus_wdata[0];
          edge_d[k] = bus_wdata[1];
        end
      end
    end
    if (bus_we && (region == RG_CFG) && (idx == '0)) rev_d = bus_wdata[0];
    if (csr_we && (csr_sel == CS_VBASE)) vbase_d = csr_wdata[31:10];
    if (csr_we && (csr_sel == CS_THR))   thr_d   = csr_wdata[PRIO_W-1:0];
    if (csr_we && (csr_sel == CS_CUR))   cur_d   = csr_wdata[PRIO_W-1:0];
    if (capt) begin
      cid_d   = best_id;
      cprio_d = best_prio;
    end
    irq_d = (best_urg > urgency(thr_q, rev_q)) && (best_urg > urgency(cur_q, rev_q));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int k = 1; k <= NUM_SRC; k++) prio_q[k] <= '0;
      en_q    <= '0;
      pol_q   <= '0;
      edge_q  <= '0;
      rev_q   <= 1'b0;
      thr_q   <= '0;
      cur_q   <= '0;
      vbase_q <= '0;
      cid_q   <= '0;
      cprio_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      prio_q  <= prio_d;
      en_q    <= en_d;
      pol_q   <= pol_d;
      edge_q  <= edge_d;
      rev_q   <= rev_d;
      thr_q   <= thr_d;
      cur_q   <= cur_d;
      vbase_q <= vbase_d;
      cid_q   <= cid_d;
      cprio_q <= cprio_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

  // Read paths
  always_comb begin
    pend_map = '0;
    for (int k = 1; k <= NUM_SRC; k++) pend_map[k] = pend[k];
    bus_rdata = '0;
    case (region)
      RG_PRIO:  for (int k = 1; k <= NUM_SRC; k++)
                  if (int'(idx) == k) bus_rdata = {{(32-PRIO_W){1'b0}}, prio_q[k]};
      RG_EN:    for (int k = 1; k <= NUM_SRC; k++)
                  if (int'(idx) == k) bus_rdata = {31'b0, en_q[k]};
      RG_GWCTL: for (int k = 1; k <= NUM_SRC; k++)
                  if (int'(idx) == k) bus_rdata = {30'b0, edge_q[k], pol_q[k]};
      RG_PEND:  for (int w = 0; w < PEND_WORDS; w++)
                  if (int'(idx) == w) bus_rdata = pend_map[w*32 +: 32];
      RG_CFG:   if (idx == '0) bus_rdata = {31'b0, rev_q};
      default:  bus_rdata = '0;
    endcase
  end

  always_comb begin
    hap_id = '0;
    hap_id[ID_W-1:0] = cid_q;
    case (csr_sel)
      CS_VBASE: csr_rdata = {vbase_q, 10'b0};
      CS_THR:   csr_rdata = {{(32-PRIO_W){1'b0}}, thr_q};
      CS_CPRIO: csr_rdata = {{(32-PRIO_W){1'b0}}, cprio_q};
      CS_CUR:   csr_rdata = {{(32-PRIO_W){1'b0}}, cur_q};
      CS_HAP:   csr_rdata = {vbase_q, hap_id, 2'b00};
      default:  csr_rdata = '0;
    endcase
  end

  // R8 R9
  win_valid_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (best_id != '0) |-> {cand, 1'b0}[best_id]);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_o |-> ($past(best_id) != '0));
  // R10
  capture_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    capt |=> (cid_q == $past(best_id)));
  // R10
  claim_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (capt && (best_id == '0)) |=> (cprio_q == '0));
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk, rst_n;
  logic [N:1]  irq_src;
  logic        bus_we, csr_we, irq_o;
  logic [14:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata, csr_wdata, csr_rdata;
  logic [2:0]  csr_sel;

  ext_irq_ctrl #(.NUM_SRC(N), .ADDR_W(15)) u_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .csr_we(csr_we), .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .irq_o(irq_o)
  );

  int n_tests = 0, n_fail = 0;
  bit model_on = 0, done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_prio [1:N];
  bit m_en [1:N], m_pol [1:N], m_edge [1:N], m_sticky [1:N], m_prev [1:N];
  bit m_rev = 0, m_irq = 0;
  int m_thr = 0, m_cur = 0;

  initial for (int k = 1; k <= N; k++) begin
    m_prio[k] = 0; m_en[k] = 0; m_pol[k] = 0; m_edge[k] = 0; m_sticky[k] = 0; m_prev[k] = 0;
  end

  function automatic int urg(int p);
    return m_rev ? 15 - p : p;
  endfunction

  function automatic bit m_pend(int k);
    return m_edge[k] ? m_sticky[k] : (irq_src[k] ^ m_pol[k]);
  endfunction

  always @(posedge clk) if (model_on) begin
    int win, best, rg, ix;
    bit act;
    win = 0; best = 0;
    for (int k = 1; k <= N; k++)
      if (m_pend(k) && m_en[k] && urg(m_prio[k]) > best) begin
        win = k; best = urg(m_prio[k]);
      end
    rg = int'(bus_addr[14:12]);
    ix = int'(bus_addr[11:2]);
    for (int k = 1; k <= N; k++) begin
      act = irq_src[k] ^ m_pol[k];
      if (m_edge[k] && act && !m_prev[k]) m_sticky[k] = 1;
      else if (bus_we && rg == 3 && ix == k) m_sticky[k] = 0;
      m_prev[k] = act;
    end
    m_irq = (best > urg(m_thr)) && (best > urg(m_cur));
    if (bus_we && ix >= 1 && ix <= N) begin
      if (rg == 0) m_prio[ix] = int'(bus_wdata[3:0]);
      if (rg == 1) m_en[ix] = bus_wdata[0];
      if (rg == 2) begin m_pol[ix] = bus_wdata[0]; m_edge[ix] = bus_wdata[1]; end
    end
    if (bus_we && rg == 5 && ix == 0) m_rev = bus_wdata[0];
    if (csr_we && csr_sel == 1) m_thr = int'(csr_wdata[3:0]);
    if (csr_we && csr_sel == 4) m_cur = int'(csr_wdata[3:0]);
  end

  // R6 R7 R8 R9: irq_o compared with the model on every clock
  always @(negedge clk) if (model_on && !done) chk("R6 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq});

  function automatic logic [14:0] ad(int rg, int ix);
    return {rg[2:0], ix[9:0], 2'b00};
  endfunction

  task automatic bus_wr(int rg, int ix, logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1; bus_addr = ad(rg, ix); bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 0;
  endtask

  task automatic bus_rd(string tag, int rg, int ix, logic [31:0] exp);
    @(posedge clk); #1;
    bus_addr = ad(rg, ix); #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic csr_wr(int s, logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1; csr_sel = s[2:0]; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
  endtask

  task automatic csr_rd(string tag, int s, logic [31:0] exp);
    @(posedge clk); #1;
    csr_sel = s[2:0]; #1;
    chk(tag, csr_rdata, exp);
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    #2;
  endtask

  task automatic irq_is(string tag, bit exp);
    settle();
    chk(tag, {31'b0, irq_o}, {31'b0, exp});
  endtask

  initial begin
    rst_n = 0; irq_src = '0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    csr_we = 0; csr_sel = '0; csr_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1 model_on = 1;

    // R1 reset state
    chk("R1 irq_o after reset", {31'b0, irq_o}, 32'h0);
    bus_rd("R1 priority 1", 0, 1, 32'h0);
    bus_rd("R1 order bit", 5, 0, 32'h0);
    csr_rd("R1 handler address", 5, 32'h0);
    csr_rd("R1 threshold", 1, 32'h0);

    // R2 priority/enable storage
    bus_wr(0, 3, 32'hFFFF_FFF5);
    bus_rd("R2 priority 3", 0, 3, 32'h5);
    bus_wr(0, 0, 32'h7);
    bus_rd("R2 index 0 ignored", 0, 0, 32'h0);
    bus_wr(0, 9, 32'h7);
    bus_rd("R2 index above N ignored", 0, 9, 32'h0);
    bus_wr(1, 3, 32'hFFFF_FFFF);
    bus_rd("R2 enable 3", 1, 3, 32'h1);

    // R12 CSR storage
    csr_wr(0, 32'hFFFF_FFFF);
    csr_rd("R12 vector base", 0, 32'hFFFF_FC00);
    csr_wr(1, 32'h37);
    csr_rd("R12 threshold", 1, 32'h7);
    csr_wr(1, 32'h0);

    // R3 R5 level gateways and pending map
    irq_src[3] = 1;
    bus_wr(2, 6, 32'h1);
    bus_rd("R3 gateway ctl 6", 2, 6, 32'h1);
    bus_rd("R5 pending word 0", 4, 0, 32'h48);
    bus_wr(2, 6, 32'h0);
    bus_rd("R3 polarity restored", 4, 0, 32'h08);

    // R6 threshold and current priority
    irq_is("R6 irq raised", 1);
    csr_wr(1, 5);
    irq_is("R6 equal threshold blocks", 0);
    csr_wr(1, 4);
    irq_is("R6 lower threshold passes", 1);
    csr_wr(4, 5);
    irq_is("R6 current priority blocks", 0);
    csr_wr(4, 0);
    csr_wr(1, 0);
    irq_is("R6 irq again", 1);

    // R9 R10 R11 tie resolved to lowest ID
    bus_wr(0, 2, 5);
    bus_wr(1, 2, 1);
    @(posedge clk); #1 irq_src[2] = 1;
    settle();
    csr_wr(2, 0);
    csr_rd("R9 R11 handler address tie", 5, 32'hFFFF_FC08);
    csr_rd("R10 claimed priority", 3, 32'h5);

    // R8 disabled and zero priority
    bus_wr(1, 2, 0);
    bus_wr(1, 3, 0);
    irq_is("R8 disabled sources", 0);
    bus_wr(1, 2, 1);
    bus_wr(1, 3, 1);
    bus_wr(0, 2, 0);
    bus_wr(0, 3, 0);
    irq_is("R8 priority 0 never wins", 0);
    csr_wr(2, 0);
    csr_rd("R10 no winner id", 5, 32'hFFFF_FC00);
    csr_rd("R10 no winner priority", 3, 32'h0);

    // R7 reversed order
    bus_wr(5, 0, 1);
    csr_wr(1, 15);
    csr_wr(4, 15);
    bus_wr(0, 2, 3);
    bus_wr(0, 3, 9);
    irq_is("R7 reversed raises", 1);
    csr_wr(2, 0);
    csr_rd("R7 smaller number wins", 5, 32'hFFFF_FC08);
    csr_rd("R7 claimed priority", 3, 32'h3);
    csr_wr(1, 3);
    irq_is("R7 equal threshold blocks", 0);
    csr_wr(1, 15);
    bus_wr(0, 2, 15);
    bus_wr(0, 3, 15);
    irq_is("R8 priority 15 in reversed order", 0);
    bus_wr(5, 0, 0);
    csr_wr(1, 0);
    csr_wr(4, 0);

    // R4 edge gateway
    bus_wr(1, 2, 0);
    bus_wr(1, 3, 0);
    @(posedge clk); #1 irq_src[2] = 0; irq_src[3] = 0;
    bus_wr(0, 5, 4);
    bus_wr(1, 5, 1);
    bus_wr(2, 5, 2);
    irq_is("R4 no edge yet", 0);
    @(posedge clk); #1 irq_src[5] = 1;
    @(posedge clk); #1 irq_src[5] = 0;
    bus_rd("R4 sticky pending", 4, 0, 32'h20);
    irq_is("R4 edge raises irq", 1);
    csr_wr(2, 0);
    csr_rd("R4 edge source claimed", 5, 32'hFFFF_FC14);
    bus_wr(3, 5, 32'h0);
    bus_rd("R4 cleared", 4, 0, 32'h0);
    irq_is("R4 irq drops after clear", 0);

    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog act 0 exp 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule